// File: doc/BRIEF.md
# Channel Queue Control Block

This block is the register set and control state for one channel of a multi-channel copy engine that takes its work from a submission ring and reports it through a completion ring. It decodes a 32-bit register bus inside one 256-byte channel window. The window holds both ring base addresses, both ring sizes, the software-owned ring pointers, the run and reset controls, a readable channel state code and a 13-bit interrupt status with its mask. Channel n of a multi-channel engine sits at the engine base plus n times 0x100, and only the low 8 address bits reach this block.

Software programs each ring size as the entry count minus one. It enables the channel and then moves the submission tail to hand over work. The block keeps the hardware-side pointers: the next submission slot to launch and the next completion slot to fill. It starts the data mover with a one-cycle pulse, waits for its completion or error, and raises interrupt status bits. The data mover itself sits outside and is reached through start, slot, busy, done and error ports.

The channel state machine has eight states, with codes readable at offset 0x30:
- IDLE (0) and RUN (1).
- CMPL (2): a one-cycle completion.
- PAUSE (3), HALT (4) and ABORT (5).
- WAIT (6): work is pending but blocked by a busy mover or a full completion ring.
- FLUSH (7): the one cycle in which a queue reset is applied.

The transitions are as follows:
- HALT goes to IDLE (or PAUSE) on enable.
- IDLE, CMPL and WAIT go to RUN on launch, to WAIT when work is blocked, to PAUSE on pause, and to HALT on disable.
- RUN goes to CMPL on a clean done and to ABORT on an error done.
- PAUSE goes to IDLE when pause clears and to HALT when enable clears.
- Any state goes to FLUSH on queue reset, and FLUSH always goes to IDLE.

Top module: `chq_ctrl`

## Requirements
- R1: Register offsets within the window are as follows. Submission base low and high are at 0x00 and 0x04, submission size at 0x08 and submission tail at 0x0C. Completion base low and high are at 0x10 and 0x14, completion size at 0x18 and completion head at 0x1C. The run control is at 0x20 (bit 0 enable, bit 4 pause), the reset control at 0x24 (bit 0), the state at 0x30 (bits 3:0), interrupt status at 0x40 and interrupt mask at 0x44. Size and pointer registers are 16 bits wide. Writes to 0x30 and to unmapped offsets have no effect, and unmapped offsets read zero.
- R2: A ring sized N holds N+1 slots. The hardware pointers advance from N back to 0.
- R3: A launch occurs when enable is set, pause is clear, the submission tail differs from the launch pointer, the mover is not busy and the completion ring is not full. A launch gives a one-cycle start pulse in the first RUN cycle, with the launched slot on the slot output.
- R4: The state reads 0 when IDLE and 1 during RUN, starting the cycle after the tail write that supplies work.
- R5: A clean done in RUN gives exactly one CMPL cycle (code 2), advances the completion slot output and sets interrupt status bit 0.
- R6: Pending work waits in WAIT (code 6) while the mover is busy, or while the next completion slot equals the completion head (ring full). It launches once the blocking condition clears.
- R7: Setting pause while in RUN lets the current descriptor finish. The channel then goes to PAUSE (code 3) and launches nothing until pause clears.
- R8: After reset the state is HALT (code 4) and the mask is all ones. Clearing enable in RUN leads to HALT after the current completion, and setting enable from HALT returns to IDLE.
- R9: An error done in RUN goes to ABORT (code 5) and sets interrupt status bit 1 without advancing the completion slot. ABORT holds until a queue reset.
- R10: Writing 1 to reset bit 0 raises it for one cycle. FLUSH (code 7) follows, and then IDLE. The reset zeroes the tail, head, launch and completion pointers, and it overrides a launch that would occur in the same cycle.
- R11: Interrupt status bits are write-one-to-clear, and a source event in the same cycle as its clear leaves the bit set. The interrupt output is high when any status bit is set and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset within the channel window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sq_base_addr | output | 64 | Submission ring base address |
| cq_base_addr | output | 64 | Completion ring base address |
| eng_start | output | 1 | One-cycle launch pulse to the mover |
| eng_slot | output | PTR_W | Submission slot of the launched descriptor |
| cq_slot | output | PTR_W | Next completion slot to be written |
| eng_busy | input | 1 | Mover cannot accept a launch |
| eng_done | input | 1 | Mover finished the current descriptor |
| eng_err | input | 1 | Qualifies eng_done as a failed descriptor |
| eng_event | input | IRQ_W | Extra interrupt source pulses, one per status bit |
| irq | output | 1 | Channel interrupt |

## Verification
Two collisions are provoked on purpose. The first is a queue reset that lands in the cycle where a blocked launch would fire. The busy input is dropped in the cycle after the reset write, so both the reset bit and the launch condition are true on the same edge. The bench then requires no start pulse, FLUSH, and zeroed pointers. The second is an interrupt source pulse raised in the same cycle as a write-one-to-clear aimed at both that bit and another bit. There, the driven bit must stay set while the other clears.

// File: rtl/chq_pkg.sv
package chq_pkg;

    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] A_SQ_LO   = 8'h00;
    localparam logic [REG_AW-1:0] A_SQ_HI   = 8'h04;
    localparam logic [REG_AW-1:0] A_SQ_SIZE = 8'h08;
    localparam logic [REG_AW-1:0] A_SQ_TAIL = 8'h0C;
    localparam logic [REG_AW-1:0] A_CQ_LO   = 8'h10;
    localparam logic [REG_AW-1:0] A_CQ_HI   = 8'h14;
    localparam logic [REG_AW-1:0] A_CQ_SIZE = 8'h18;
    localparam logic [REG_AW-1:0] A_CQ_HEAD = 8'h1C;
    localparam logic [REG_AW-1:0] A_RUNCTL  = 8'h20;
    localparam logic [REG_AW-1:0] A_RSTCTL  = 8'h24;
    localparam logic [REG_AW-1:0] A_STATE   = 8'h30;
    localparam logic [REG_AW-1:0] A_INT_STS = 8'h40;
    localparam logic [REG_AW-1:0] A_INT_MSK = 8'h44;

    localparam int RUN_EN_BIT    = 0;
    localparam int RUN_PAUSE_BIT = 4;
    localparam int RST_BIT       = 0;

    localparam int SRC_DONE = 0;
    localparam int SRC_ERR  = 1;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_RUN   = 4'd1,
        ST_CMPL  = 4'd2,
        ST_PAUSE = 4'd3,
        ST_HALT  = 4'd4,
        ST_ABORT = 4'd5,
        ST_WAIT  = 4'd6,
        ST_FLUSH = 4'd7
    } chq_state_e;

endpackage

// File: rtl/chq_regs.sv
module chq_regs
    import chq_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [63:0]       sq_base,
    output logic [63:0]       cq_base,
    output logic [PTR_W-1:0]  sq_size,
    output logic [PTR_W-1:0]  cq_size,
    output logic [PTR_W-1:0]  sq_tail,
    output logic [PTR_W-1:0]  cq_head,
    output logic              q_en,
    output logic              q_pause,
    output logic              q_rst
);

    logic rst_hit;
    assign rst_hit = wr_en && (addr == A_RSTCTL) && wdata[RST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_base <= '0;
            cq_base <= '0;
            sq_size <= '0;
            cq_size <= '0;
            sq_tail <= '0;
            cq_head <= '0;
            q_en    <= 1'b0;
            q_pause <= 1'b0;
            q_rst   <= 1'b0;
        end else begin
            q_rst <= rst_hit;
            if (wr_en) begin
                case (addr)
                    A_SQ_LO:   sq_base[31:0]  <= wdata;
                    A_SQ_HI:   sq_base[63:32] <= wdata;
                    A_SQ_SIZE: sq_size        <= wdata[PTR_W-1:0];
                    A_SQ_TAIL: sq_tail        <= wdata[PTR_W-1:0];
                    A_CQ_LO:   cq_base[31:0]  <= wdata;
                    A_CQ_HI:   cq_base[63:32] <= wdata;
                    A_CQ_SIZE: cq_size        <= wdata[PTR_W-1:0];
                    A_CQ_HEAD: cq_head        <= wdata[PTR_W-1:0];
                    A_RUNCTL: begin
                        q_en    <= wdata[RUN_EN_BIT];
                        q_pause <= wdata[RUN_PAUSE_BIT];
                    end
                    default: ;
                endcase
            end
            if (q_rst) begin
                sq_tail <= '0;
                cq_head <= '0;
            end
        end
    end

    // R10
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_rst && !rst_hit) |=> !q_rst);

    // R10
    rst_zero_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_rst |=> (sq_tail == '0 && cq_head == '0));

endmodule

// File: rtl/chq_fsm.sv
module chq_fsm
    import chq_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_en,
    input  logic             q_pause,
    input  logic             q_rst,
    input  logic [PTR_W-1:0] sq_size,
    input  logic [PTR_W-1:0] cq_size,
    input  logic [PTR_W-1:0] sq_tail,
    input  logic [PTR_W-1:0] cq_head,
    input  logic             eng_busy,
    input  logic             eng_done,
    input  logic             eng_err,
    output chq_state_e       state,
    output logic             eng_start,
    output logic [PTR_W-1:0] eng_slot,
    output logic [PTR_W-1:0] cq_slot,
    output logic             evt_done,
    output logic             evt_err
);

    function automatic logic [PTR_W-1:0] ring_step(input logic [PTR_W-1:0] p,
                                                   input logic [PTR_W-1:0] last);
        return (p == last) ? '0 : p + 1'b1;
    endfunction

    chq_state_e       state_q, state_nx;
    logic [PTR_W-1:0] launch_ptr;
    logic [PTR_W-1:0] fill_ptr;
    logic             start_q;
    logic [PTR_W-1:0] slot_q;
    logic             pending, cq_full, go, launch;

    assign pending = (launch_ptr != sq_tail);
    assign cq_full = (ring_step(fill_ptr, cq_size) == cq_head);
    assign go      = q_en && !q_pause && pending && !eng_busy && !cq_full;

    // next-state process
    always_comb begin
        state_nx = state_q;
        if (q_rst) begin
            state_nx = ST_FLUSH;
        end else begin
            unique case (state_q)
                ST_FLUSH: state_nx = ST_IDLE;
                ST_IDLE, ST_CMPL, ST_WAIT: begin
                    if (!q_en)        state_nx = ST_HALT;
                    else if (q_pause) state_nx = ST_PAUSE;
                    else if (go)      state_nx = ST_RUN;
                    else if (pending) state_nx = ST_WAIT;
                    else              state_nx = ST_IDLE;
                end
                ST_RUN: begin
                    if (eng_done) state_nx = eng_err ? ST_ABORT : ST_CMPL;
                end
                ST_PAUSE: begin
                    if (!q_en)         state_nx = ST_HALT;
                    else if (!q_pause) state_nx = ST_IDLE;
                end
                ST_HALT: begin
                    if (q_en) state_nx = q_pause ? ST_PAUSE : ST_IDLE;
                end
                ST_ABORT: state_nx = ST_ABORT;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_nx;
    end

    // output and pointer process
    always_comb begin
        launch   = (state_nx == ST_RUN) && (state_q != ST_RUN);
        evt_done = (state_q == ST_RUN) && eng_done && !eng_err && !q_rst;
        evt_err  = (state_q == ST_RUN) && eng_done && eng_err && !q_rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            launch_ptr <= '0;
            fill_ptr   <= '0;
            start_q    <= 1'b0;
            slot_q     <= '0;
        end else if (q_rst) begin
            launch_ptr <= '0;
            fill_ptr   <= '0;
            start_q    <= 1'b0;
            slot_q     <= '0;
        end else begin
            start_q <= launch;
            if (launch) begin
                slot_q     <= launch_ptr;
                launch_ptr <= ring_step(launch_ptr, sq_size);
            end
            if (evt_done) fill_ptr <= ring_step(fill_ptr, cq_size);
        end
    end

    assign state     = state_q;
    assign eng_start = start_q;
    assign eng_slot  = slot_q;
    assign cq_slot   = fill_ptr;

    // R3
    start_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (state_q == ST_RUN));

    // R5
    cmpl_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMPL) |=> (state_q != ST_CMPL));

    // R7
    pause_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pause && state_q != ST_RUN) |=> !eng_start);

    // R9
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ABORT && !q_rst) |=> (state_q == ST_ABORT));

    // R10
    flush_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_rst |=> (state_q == ST_FLUSH && !eng_start));

endmodule

// File: rtl/chq_irq.sv
module chq_irq #(
    parameter int IRQ_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic             mask_wr,
    input  logic [IRQ_W-1:0] wdata,
    input  logic [IRQ_W-1:0] set_vec,
    output logic [IRQ_W-1:0] sts,
    output logic [IRQ_W-1:0] mask,
    output logic             irq
);

    logic [IRQ_W-1:0] clr_vec;
    assign clr_vec = clr_en ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts  <= '0;
            mask <= '1;
        end else begin
            sts <= (sts & ~clr_vec) | set_vec;
            if (mask_wr) mask <= wdata;
        end
    end

    assign irq = |(sts & ~mask);

    // R11
    w1c_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && (&wdata) && set_vec == '0) |=> (sts == '0));

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && set_vec != '0) |=> ((sts & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/chq_ctrl.sv
module chq_ctrl
    import chq_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int IRQ_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [63:0]       sq_base_addr,
    output logic [63:0]       cq_base_addr,
    output logic              eng_start,
    output logic [PTR_W-1:0]  eng_slot,
    output logic [PTR_W-1:0]  cq_slot,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic [IRQ_W-1:0]  eng_event,
    output logic              irq
);

    logic [PTR_W-1:0] sq_size, cq_size, sq_tail, cq_head;
    logic             q_en, q_pause, q_rst;
    chq_state_e       state;
    logic             evt_done, evt_err;
    logic [IRQ_W-1:0] sts, mask, set_vec;

    chq_regs #(.PTR_W(PTR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .sq_base (sq_base_addr),
        .cq_base (cq_base_addr),
        .sq_size (sq_size),
        .cq_size (cq_size),
        .sq_tail (sq_tail),
        .cq_head (cq_head),
        .q_en    (q_en),
        .q_pause (q_pause),
        .q_rst   (q_rst)
    );

    chq_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .q_en     (q_en),
        .q_pause  (q_pause),
        .q_rst    (q_rst),
        .sq_size  (sq_size),
        .cq_size  (cq_size),
        .sq_tail  (sq_tail),
        .cq_head  (cq_head),
        .eng_busy (eng_busy),
        .eng_done (eng_done),
        .eng_err  (eng_err),
        .state    (state),
        .eng_start(eng_start),
        .eng_slot (eng_slot),
        .cq_slot  (cq_slot),
        .evt_done (evt_done),
        .evt_err  (evt_err)
    );

    always_comb begin
        set_vec           = eng_event;
        set_vec[SRC_DONE] = eng_event[SRC_DONE] | evt_done;
        set_vec[SRC_ERR]  = eng_event[SRC_ERR]  | evt_err;
    end

    chq_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (reg_wr && reg_addr == A_INT_STS),
        .mask_wr (reg_wr && reg_addr == A_INT_MSK),
        .wdata   (reg_wdata[IRQ_W-1:0]),
        .set_vec (set_vec),
        .sts     (sts),
        .mask    (mask),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_SQ_LO:   reg_rdata = sq_base_addr[31:0];
            A_SQ_HI:   reg_rdata = sq_base_addr[63:32];
            A_SQ_SIZE: reg_rdata = 32'(sq_size);
            A_SQ_TAIL: reg_rdata = 32'(sq_tail);
            A_CQ_LO:   reg_rdata = cq_base_addr[31:0];
            A_CQ_HI:   reg_rdata = cq_base_addr[63:32];
            A_CQ_SIZE: reg_rdata = 32'(cq_size);
            A_CQ_HEAD: reg_rdata = 32'(cq_head);
            A_RUNCTL: begin
                reg_rdata[RUN_EN_BIT]    = q_en;
                reg_rdata[RUN_PAUSE_BIT] = q_pause;
            end
            A_RSTCTL:  reg_rdata[RST_BIT] = q_rst;
            A_STATE:   reg_rdata = 32'(state);
            A_INT_STS: reg_rdata = 32'(sts);
            A_INT_MSK: reg_rdata = 32'(mask);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/chq_ctrl_bench.sv
module chq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] sq_base_addr, cq_base_addr;
    logic        eng_start;
    logic [15:0] eng_slot, cq_slot;
    logic        eng_busy = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_err = 1'b0;
    logic [12:0] eng_event = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [31:0] d;

    always #4 clk = ~clk;

    chq_ctrl u_chq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sq_base_addr(sq_base_addr), .cq_base_addr(cq_base_addr),
        .eng_start(eng_start), .eng_slot(eng_slot), .cq_slot(cq_slot),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_err(eng_err),
        .eng_event(eng_event), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_job(input logic err);
        eng_done = 1'b1; eng_err = err;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0;
    endtask

    function automatic logic [31:0] pat(input int off);
        return 32'h9E37_79B9 ^ (32'(off) * 32'h0101_0101);
    endfunction

    function automatic logic [31:0] sweep_exp(input int off);
        case (off)
            'h00, 'h04, 'h10, 'h14: return pat(off);
            'h08, 'h0C, 'h18, 'h1C: return pat(off) & 32'hFFFF;
            'h30: return 32'd4;
            'h44: return pat(off) & 32'h1FFF;
            default: return 32'd0;
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // R8 reset state
        rd(8'h30, d); chk("R8 reset state HALT", d, 4);
        rd(8'h44, d); chk("R8 reset mask", d, 32'h1FFF);
        chk("R11 reset irq", irq, 0);
        chk("R3 reset start", eng_start, 0);

        // R1 sweep of the window
        for (int off = 0; off < 256; off += 4)
            if (off != 'h20 && off != 'h24 && off != 'h40) wr(8'(off), pat(off));
        for (int off = 0; off < 256; off += 4) begin
            rd(8'(off), d);
            chk($sformatf("R1 readback off 0x%0h", off), d, sweep_exp(off));
        end
        chk("R1 sq base port", sq_base_addr, {pat('h04), pat('h00)});
        chk("R1 cq base port", cq_base_addr, {pat('h14), pat('h10)});

        // R10 queue reset
        wr(8'h24, 1);
        step(1);
        rd(8'h24, d); chk("R10 reset self clear", d, 0);
        rd(8'h30, d); chk("R10 FLUSH state", d, 7);
        step(1);
        rd(8'h30, d); chk("R10 IDLE after FLUSH", d, 0);
        rd(8'h0C, d); chk("R10 tail zero", d, 0);
        rd(8'h1C, d); chk("R10 head zero", d, 0);
        chk("R10 cq slot zero", cq_slot, 0);

        // setup: 4-slot rings
        wr(8'h08, 3); wr(8'h18, 3); wr(8'h44, 0); wr(8'h20, 1);
        step(1);
        rd(8'h30, d); chk("R8 HALT to IDLE on enable", d, 0);

        for (int k = 0; k < 3; k++) begin
            wr(8'h0C, 32'((k + 1) % 4));
            step(1);
            chk("R3 start pulse", eng_start, 1);
            chk("R3 slot", eng_slot, 16'(k));
            rd(8'h30, d); chk("R4 RUN code", d, 1);
            step(1);
            chk("R3 start one cycle", eng_start, 0);
            finish_job(1'b0);
            rd(8'h30, d); chk("R5 CMPL code", d, 2);
            chk("R5 cq slot advance", cq_slot, 16'(k + 1));
            chk("R11 irq on done", irq, 1);
            rd(8'h40, d); chk("R5 status bit0", d, 1);
            wr(8'h40, 1);
            rd(8'h30, d); chk("R4 back to IDLE", d, 0);
            chk("R11 irq cleared", irq, 0);
        end

        // R6 completion ring full, R2 wrap
        wr(8'h0C, 0);
        step(1);
        rd(8'h30, d); chk("R6 WAIT on full", d, 6);
        chk("R6 no start on full", eng_start, 0);
        step(3);
        rd(8'h30, d); chk("R6 still WAIT", d, 6);
        wr(8'h1C, 2);
        step(1);
        chk("R6 start after head move", eng_start, 1);
        chk("R2 sq slot 3", eng_slot, 3);
        finish_job(1'b0);
        chk("R2 cq slot wraps", cq_slot, 0);
        step(1);
        wr(8'h40, 32'h1FFF);
        wr(8'h1C, 0);

        // R6 busy
        eng_busy = 1'b1;
        wr(8'h0C, 1);
        step(1);
        rd(8'h30, d); chk("R6 WAIT on busy", d, 6);
        chk("R6 no start busy", eng_start, 0);
        eng_busy = 1'b0;
        step(1);
        chk("R6 start after busy", eng_start, 1);
        chk("R2 sq slot wrapped to 0", eng_slot, 0);
        finish_job(1'b0);
        chk("R5 cq slot 1", cq_slot, 1);
        step(1);

        // R7 pause
        wr(8'h0C, 2);
        step(1);
        chk("R7 start before pause", eng_start, 1);
        wr(8'h20, 32'h11);
        rd(8'h30, d); chk("R7 RUN holds under pause", d, 1);
        finish_job(1'b0);
        rd(8'h30, d); chk("R7 CMPL under pause", d, 2);
        step(1);
        rd(8'h30, d); chk("R7 PAUSE code", d, 3);
        wr(8'h0C, 3);
        step(3);
        rd(8'h30, d); chk("R7 stays PAUSE", d, 3);
        chk("R7 no start paused", eng_start, 0);
        wr(8'h20, 1);
        step(1);
        rd(8'h30, d); chk("R7 IDLE after unpause", d, 0);
        step(1);
        chk("R7 start after unpause", eng_start, 1);
        chk("R7 slot 2", eng_slot, 2);

        // R8 disable during RUN
        wr(8'h20, 0);
        rd(8'h30, d); chk("R8 RUN holds when disabled", d, 1);
        finish_job(1'b0);
        step(1);
        rd(8'h30, d); chk("R8 HALT after completion", d, 4);
        chk("R8 cq slot 3", cq_slot, 3);

        // R9 error
        wr(8'h40, 32'h1FFF);
        wr(8'h1C, 3);
        wr(8'h20, 1);
        wr(8'h0C, 0);
        step(1);
        chk("R9 start slot 3", eng_start, 1);
        chk("R9 slot", eng_slot, 3);
        finish_job(1'b1);
        rd(8'h30, d); chk("R9 ABORT code", d, 5);
        rd(8'h40, d); chk("R9 status bit1", d, 2);
        chk("R9 cq slot held", cq_slot, 3);
        wr(8'h0C, 1);
        step(3);
        rd(8'h30, d); chk("R9 ABORT sticky", d, 5);
        chk("R9 no start in ABORT", eng_start, 0);
        wr(8'h24, 1);
        step(1);
        rd(8'h30, d); chk("R10 FLUSH from ABORT", d, 7);
        step(1);
        rd(8'h30, d); chk("R10 IDLE after FLUSH", d, 0);
        step(1);
        rd(8'h30, d); chk("R10 IDLE stays, no work", d, 0);
        chk("R10 eng slot zero", eng_slot, 0);
        chk("R10 cq slot zero", cq_slot, 0);

        // R10 reset collides with launch
        eng_busy = 1'b1;
        wr(8'h0C, 1);
        step(1);
        rd(8'h30, d); chk("R6 WAIT before collision", d, 6);
        reg_wr = 1'b1; reg_addr = 8'h24; reg_wdata = 1;
        @(negedge clk);
        reg_wr = 1'b0; eng_busy = 1'b0;
        step(1);
        chk("R10 reset beats launch", eng_start, 0);
        rd(8'h30, d); chk("R10 FLUSH on collision", d, 7);
        step(1);
        chk("R10 still no start", eng_start, 0);
        rd(8'h30, d); chk("R10 IDLE after collision", d, 0);
        rd(8'h0C, d); chk("R10 tail cleared", d, 0);

        // R11 set versus clear
        wr(8'h40, 32'h1FFF);
        @(negedge clk); eng_event = 13'h40;
        @(negedge clk); eng_event = '0;
        reg_wr = 1'b1; reg_addr = 8'h40; reg_wdata = 32'h60; eng_event = 13'h20;
        @(negedge clk);
        reg_wr = 1'b0; eng_event = '0;
        rd(8'h40, d); chk("R11 set wins over clear", d, 32'h20);
        wr(8'h44, 32'h1FDF);
        chk("R11 irq unmasked bit", irq, 1);
        wr(8'h44, 32'h1FFF);
        chk("R11 irq masked", irq, 0);
        rd(8'h40, d); chk("R11 status kept when masked", d, 32'h20);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule